// File: doc/BRIEF.md
# Dual-Mode Peripheral Interrupt Controller

This block is the interrupt logic of a two-channel serial peripheral. It collects a set of level-sensitive interrupt sources into pending flags. It gates those flags with a software mask and drives one active-low request line to the CPU. Two of the sources are derived from the receive status byte of each channel. The upper four bits of that byte carry the receive error flags (parity, overrun, framing), and any of them being set means the received character is suspect. Software clears each pending flag with its own clear strobe. The request line then releases by itself once no enabled flag remains, and no acknowledge is needed for that.

The controller has two operating modes. After a hardware reset it is in plain mode. In plain mode the CPU finds its service routine by external means: the acknowledge input is ignored and the data-bus driver stays off. A "go vectored" command written to the command register switches the block to vectored mode. In vectored mode, an acknowledge cycle that finds an enabled request pending makes the block drive its 8-bit vector register onto the data bus. A "go plain" command or a hardware reset returns the block to plain mode.

All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake is used. The vector appears on the bus output in the same cycle as the acknowledge, qualified by its output enable.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_n` is 1, `ack_doe` is 0, the mask register (address 0) reads 0x00, the vector register (address 1) reads 0x0F, and the block is in plain mode.
- R2: A source that is high at a clock edge sets its pending flag. The flag stays set until its clear strobe (`src_clr` bit i) is applied while the source is low. If the source is still high, the set wins.
- R3: `irq_n` is 0 exactly when some pending flag has its mask bit set. Mask bit i (address 0, bit i) enables source i. Sources 0 to 5 are `src_lvl` bits 0 to 5.
- R4: `irq_n` returns to 1 once every enabled pending flag is cleared, with no acknowledge.
- R5: Source 6 is high while bits 7:4 of `rx_stat_a` are nonzero. Source 7 is high while bits 7:4 of `rx_stat_b` are nonzero. Bits 3:0 of both status bytes have no effect.
- R6: A write to address 1 loads the vector register, and a read of address 1 returns it.
- R7: Writing 0xA1 to address 2 selects vectored mode. Writing 0xA0 selects plain mode. Any other value written there leaves the mode unchanged.
- R8: In vectored mode, with `iack` high and an enabled request pending, `ack_doe` is 1 and `ack_dout` equals the vector register, in the same cycle.
- R9: In plain mode, `iack` has no effect: `ack_doe` stays 0, `ack_dout` stays 0x00, and `irq_n` is unchanged.
- R10: In vectored mode, `iack` with no enabled request pending leaves `ack_doe` at 0.
- R11: A hardware reset taken in vectored mode returns the block to plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mask, 1 vector, 2 command) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`; 0 for addresses 2 and 3 |
| src_lvl | input | 6 | Level-sensitive general interrupt sources |
| rx_stat_a | input | 8 | Receive status byte, channel A |
| rx_stat_b | input | 8 | Receive status byte, channel B |
| src_clr | input | 8 | Per-source pending clear strobes |
| iack | input | 1 | Interrupt-acknowledge cycle active |
| irq_n | output | 1 | Interrupt request, active low |
| ack_doe | output | 1 | Data-bus output enable for the vector |
| ack_dout | output | 8 | Vector data for the bus (0 when not enabled) |

## Verification
The assertions assume that every input is a clean level sampled at the rising edge. They also assume that a clear strobe and its source can both be high in one cycle, and that the set must win in that case. The mode assertions assume that the only legal entry into vectored mode is a command write seen one cycle earlier, so they do not accept a mode change from anything else. The stimulus changes inputs only at the falling edge and holds each one for a whole cycle. It applies commands only through register writes, so these assumptions hold throughout.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 2;
  localparam logic [AW-1:0] A_MASK = 2'd0;
  localparam logic [AW-1:0] A_VEC  = 2'd1;
  localparam logic [AW-1:0] A_CMD  = 2'd2;

  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_VEC   = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC      = 8,
  parameter logic [DW-1:0] VEC_RST = 8'h0F,
  parameter logic [DW-1:0] CMD_VEC = 8'hA1,
  parameter logic [DW-1:0] CMD_PLN = 8'hA0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] mask_q,
  output logic [DW-1:0]   vec_q,
  output irq_mode_e       mode_q
);
  logic wr_mask, wr_vec, wr_cmd;

  assign wr_mask = wr && (addr == A_MASK);
  assign wr_vec  = wr && (addr == A_VEC);
  assign wr_cmd  = wr && (addr == A_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      vec_q  <= VEC_RST;
      mode_q <= MODE_PLAIN;
    end else begin
      if (wr_mask) mask_q <= wdata[NSRC-1:0];
      if (wr_vec)  vec_q  <= wdata;
      if (wr_cmd) begin
        if (wdata == CMD_VEC)      mode_q <= MODE_VEC;
        else if (wdata == CMD_PLN) mode_q <= MODE_PLAIN;
      end
    end
  end

  always_comb begin
    case (addr)
      A_MASK:  rdata = DW'(mask_q);
      A_VEC:   rdata = vec_q;
      default: rdata = '0;
    endcase
  end

  // R7: vectored mode is entered only by the go-vectored command
  assert_vec_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_VEC && $past(mode_q) == MODE_PLAIN)
      |-> $past(wr && addr == A_CMD && wdata == CMD_VEC));

  // R7: outside reset, plain mode is re-entered only by the go-plain command
  assert_vec_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PLAIN && $past(mode_q) == MODE_VEC)
      |-> $past(wr && addr == A_CMD && wdata == CMD_PLN));
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int unsigned NEXT = 6,
  parameter int unsigned NCH  = 2,
  localparam int unsigned NSRC = NEXT + NCH,
  localparam int unsigned NIB  = DW / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEXT-1:0]   src_ext,
  input  logic [NCH*DW-1:0] stat,
  input  logic [NSRC-1:0]   clr,
  output logic [NSRC-1:0]   pend_q
);
  logic [NCH-1:0]   err_lvl;
  logic [NCH*NIB-1:0] low_bits;
  logic [NSRC-1:0]  src_all;
  logic             unused_low;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign err_lvl[c] = |stat[c*DW+DW-1 -: NIB];
    assign low_bits[c*NIB +: NIB] = stat[c*DW +: NIB];
  end
  assign unused_low = ^low_bits;

  assign src_all = {err_lvl, src_ext};

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | src_all;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R2: an active source always leaves its flag set
    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      src_all[i] |=> pend_q[i]);
    // R2: a clear with the source idle drops the flag
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !src_all[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irqc_ackdrv.sv
module irqc_ackdrv
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            iack,
  input  irq_mode_e       mode,
  input  logic            req,
  input  logic [DW-1:0]   vec,
  output logic            doe,
  output logic [DW-1:0]   dout
);
  assign doe  = iack && (mode == MODE_VEC) && req;
  assign dout = doe ? vec : '0;

  // R9: plain mode never drives the bus
  assert_plain_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PLAIN) |-> (!doe && dout == '0));
  // R10: no drive without a pending enabled request
  assert_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    !req |-> !doe);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NEXT      = 6,
  parameter int unsigned NCH       = 2,
  parameter logic [DW-1:0] VEC_RST = 8'h0F,
  parameter logic [DW-1:0] CMD_VEC = 8'hA1,
  parameter logic [DW-1:0] CMD_PLN = 8'hA0,
  localparam int unsigned NSRC = NEXT + NCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NEXT-1:0] src_lvl,
  input  logic [DW-1:0]   rx_stat_a,
  input  logic [DW-1:0]   rx_stat_b,
  input  logic [NSRC-1:0] src_clr,
  input  logic            iack,
  output logic            irq_n,
  output logic            ack_doe,
  output logic [DW-1:0]   ack_dout
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend_q;
  logic [DW-1:0]   vec_q;
  irq_mode_e       mode_q;
  logic            any_req;

  irqc_regs #(
    .NSRC(NSRC), .VEC_RST(VEC_RST), .CMD_VEC(CMD_VEC), .CMD_PLN(CMD_PLN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mask_q(mask_q), .vec_q(vec_q), .mode_q(mode_q)
  );

  irqc_pending #(.NEXT(NEXT), .NCH(NCH)) u_pend (
    .clk(clk), .rst(rst), .src_ext(src_lvl), .stat({rx_stat_b, rx_stat_a}),
    .clr(src_clr), .pend_q(pend_q)
  );

  assign any_req = |(pend_q & mask_q);
  assign irq_n   = ~any_req;

  irqc_ackdrv u_ack (
    .clk(clk), .rst(rst), .iack(iack), .mode(mode_q), .req(any_req),
    .vec(vec_q), .doe(ack_doe), .dout(ack_dout)
  );

  // R8: a bus drive only happens while the request line is asserted
  assert_doe_with_irq_R8: assert property (@(posedge clk) disable iff (rst)
    ack_doe |-> !irq_n);
  // R9: in plain mode the request line ignores acknowledge
  assert_iack_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PLAIN && !irq_n && $stable(src_clr) && src_clr == '0
     && !reg_wr) |=> !irq_n);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [5:0] src_lvl;
  logic [7:0] rx_stat_a, rx_stat_b, src_clr;
  logic       iack, irq_n, ack_doe;
  logic [7:0] ack_dout;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl),
    .rx_stat_a(rx_stat_a), .rx_stat_b(rx_stat_b), .src_clr(src_clr),
    .iack(iack), .irq_n(irq_n), .ack_doe(ack_doe), .ack_dout(ack_dout)
  );

  // entry: req(4) wr(1) addr(2) wdata(8) src(6) sa(8) sb(8) clr(8) iack(1) eirq(1) edoe(1) edout(8)
  localparam int NV = 16;
  localparam logic [55:0] TBL [NV] = '{
    {4'd3,  1'b1,2'd0,8'h01, 6'h00, 8'h00,8'h00, 8'h00, 1'b0, 1'b1,1'b0,8'h00}, // R3 mask only
    {4'd3,  1'b0,2'd0,8'h00, 6'h01, 8'h00,8'h00, 8'h00, 1'b0, 1'b0,1'b0,8'h00}, // R3 request
    {4'd9,  1'b0,2'd0,8'h00, 6'h00, 8'h00,8'h00, 8'h00, 1'b1, 1'b0,1'b0,8'h00}, // R9 plain iack
    {4'd6,  1'b1,2'd1,8'h5A, 6'h00, 8'h00,8'h00, 8'h00, 1'b0, 1'b0,1'b0,8'h00}, // R6 vector write
    {4'd7,  1'b1,2'd2,8'h33, 6'h00, 8'h00,8'h00, 8'h00, 1'b1, 1'b0,1'b0,8'h00}, // R7 other cmd
    {4'd8,  1'b1,2'd2,8'hA1, 6'h00, 8'h00,8'h00, 8'h00, 1'b1, 1'b0,1'b1,8'h5A}, // R8 vectored ack
    {4'd4,  1'b0,2'd0,8'h00, 6'h00, 8'h00,8'h00, 8'h01, 1'b1, 1'b1,1'b0,8'h00}, // R4 R10 cleared
    {4'd3,  1'b0,2'd0,8'h00, 6'h02, 8'h00,8'h00, 8'h00, 1'b0, 1'b1,1'b0,8'h00}, // R3 masked src
    {4'd3,  1'b1,2'd0,8'h02, 6'h00, 8'h00,8'h00, 8'h00, 1'b0, 1'b0,1'b0,8'h00}, // R3 unmask
    {4'd2,  1'b0,2'd0,8'h00, 6'h02, 8'h00,8'h00, 8'h02, 1'b0, 1'b0,1'b0,8'h00}, // R2 set wins
    {4'd2,  1'b0,2'd0,8'h00, 6'h00, 8'h00,8'h00, 8'h02, 1'b0, 1'b1,1'b0,8'h00}, // R2 clear
    {4'd5,  1'b1,2'd0,8'hC0, 6'h00, 8'h0F,8'h07, 8'h00, 1'b1, 1'b1,1'b0,8'h00}, // R5 low nibble
    {4'd5,  1'b0,2'd0,8'h00, 6'h00, 8'h20,8'h00, 8'h00, 1'b1, 1'b0,1'b1,8'h5A}, // R5 chan A err
    {4'd5,  1'b0,2'd0,8'h00, 6'h00, 8'h00,8'h00, 8'h40, 1'b0, 1'b1,1'b0,8'h00}, // R5 clear A
    {4'd5,  1'b0,2'd0,8'h00, 6'h00, 8'h00,8'h80, 8'h00, 1'b0, 1'b0,1'b0,8'h00}, // R5 chan B err
    {4'd7,  1'b1,2'd2,8'hA0, 6'h00, 8'h00,8'h00, 8'h00, 1'b1, 1'b0,1'b0,8'h00}  // R7 go plain
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; src_lvl = 0;
    rx_stat_a = 0; rx_stat_b = 0; src_clr = 0; iack = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); rst = 1;
    do_reset();
    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 1);
    chk("R1 doe", 32'(ack_doe), 0);
    reg_addr = 0; #1; chk("R1 mask", 32'(reg_rdata), 8'h00);
    reg_addr = 1; #1; chk("R1 vector", 32'(reg_rdata), 8'h0F);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr    = TBL[i][51];    reg_addr  = TBL[i][50:49];
      reg_wdata = TBL[i][48:41]; src_lvl   = TBL[i][40:35];
      rx_stat_a = TBL[i][34:27]; rx_stat_b = TBL[i][26:19];
      src_clr   = TBL[i][18:11]; iack      = TBL[i][10];
      @(posedge clk); #2;
      chk($sformatf("R%0d irq_n step %0d", TBL[i][55:52], i), 32'(irq_n), 32'(TBL[i][9]));
      chk($sformatf("R%0d doe step %0d", TBL[i][55:52], i), 32'(ack_doe), 32'(TBL[i][8]));
      chk($sformatf("R%0d dout step %0d", TBL[i][55:52], i), 32'(ack_dout), 32'(TBL[i][7:0]));
    end

    // R6 readback
    wr_reg(2'd1, 8'hC3);
    @(negedge clk); idle(); reg_addr = 1; #1;
    chk("R6 vector readback", 32'(reg_rdata), 8'hC3);

    // R11 reset from vectored mode
    do_reset();
    wr_reg(2'd2, 8'hA1);
    wr_reg(2'd0, 8'h01);
    do_reset();
    wr_reg(2'd0, 8'h01);
    @(negedge clk); idle(); src_lvl = 6'h01;
    @(posedge clk); #2;
    @(negedge clk); src_lvl = 0; iack = 1; #1;
    chk("R11 irq pending", 32'(irq_n), 0);
    chk("R11 plain after reset doe", 32'(ack_doe), 0);
    chk("R9 dout quiet", 32'(ack_dout), 0);

    // R10 vectored, iack, nothing enabled pending
    do_reset();
    wr_reg(2'd2, 8'hA1);
    @(negedge clk); idle(); src_lvl = 6'h01; iack = 1;
    @(posedge clk); #2;
    chk("R10 masked pending no drive", 32'(ack_doe), 0);
    chk("R3 masked no irq", 32'(irq_n), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule